// File: doc/BRIEF.md
# Dual-Output Registered or Transparent Word Driver

This block takes one 12-bit data word and drives two identical 12-bit output ports. A path-select input chooses the source for both ports. With the select high, the input word reaches the ports combinationally. With it low, the ports show a word register that loads on the rising clock edge.

The load enable is active-low and acts on part of the word only. When it is asserted, the register takes the whole word. When it is deasserted, the upper four bits still load and the lower eight bits keep their old value. So the upper nibble can carry a tag that changes every cycle while the low byte is held.

An active-low output enable sets both ports to high impedance. It does not stop the register from loading. A synchronous reset clears the register so that a run starts from a known value.

Top module: `dual_path_driver`

## Requirements
- R1: When `mode` is 1, both ports equal `din` combinationally, with no clock edge needed.
- R2: When `mode` is 0, both ports show the stored word register.
- R3: At a rising edge with `rst` 0 and `clkEnN` 0, all 12 bits of `din` are stored in the register.
- R4: At a rising edge with `rst` 0 and `clkEnN` 1, bits 11:8 of `din` are stored in the register and bits 7:0 keep their previous value.
- R5: `portA` and `portB` always carry the same value.
- R6: When `oeN` is 1, every bit of both ports is high impedance. When `oeN` is 0, both ports are driven.
- R7: While `oeN` is 1, the register keeps loading as set by `clkEnN`. When the ports are enabled again they show the word loaded while they were disabled.
- R8: Changing `mode` between clock edges changes the port source at once and leaves the register contents unchanged.
- R9: At a rising edge with `rst` 1, the register is cleared to 0. Reset takes priority over loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the register |
| mode | input | 1 | Path select: 1 = transparent, 0 = registered |
| clkEnN | input | 1 | Active-low full-word load enable; when high, only bits 11:8 load |
| oeN | input | 1 | Active-low output enable for both ports |
| din | input | 12 | Input data word |
| portA | output | 12 | First output copy, tri-state |
| portB | output | 12 | Second output copy, tri-state |

## Verification
The hardest case to reach is a mixed register value. This is a word whose upper nibble comes from the most recent edge while its low byte comes from an older full load. It can be seen only after a switch back to the registered path. The stimulus first loads a full word and then applies partial loads with different upper nibbles. In between it visits the transparent path, where the register still takes the upper bits. A second case checks that the register loads while the ports are disabled and that `mode` can be toggled between edges. For this the bench changes `mode` and `oeN` between clock edges and reads the ports before the next edge.

// File: rtl/dual_path_driver_pkg.sv
package dual_path_driver_pkg;

  typedef struct packed {
    logic clear;
    logic loadLow;
    logic loadHigh;
    logic selBuf;
    logic drive;
  } strobe_t;

endpackage

// File: rtl/dual_path_ctrl.sv
module dual_path_ctrl
  import dual_path_driver_pkg::*;
(
  input  logic    rst,
  input  logic    mode,
  input  logic    clkEnN,
  input  logic    oeN,
  output strobe_t stb
);

  always_comb begin
    stb.clear    = rst;
    stb.loadHigh = ~rst;
    stb.loadLow  = ~rst & ~clkEnN;
    stb.selBuf   = mode;
    stb.drive    = ~oeN;
  end

endmodule

// File: rtl/dual_path_data.sv
module dual_path_data
  import dual_path_driver_pkg::*;
#(
  parameter int WIDTH    = 12,
  parameter int LOW_BITS = 8
) (
  input  logic             clk,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] portA,
  output logic [WIDTH-1:0] portB
);

  localparam int HIGH_BITS = WIDTH - LOW_BITS;

  logic [LOW_BITS-1:0]  regLow;
  logic [HIGH_BITS-1:0] regHigh;
  logic [WIDTH-1:0]     regQ;
  logic [WIDTH-1:0]     outWord;

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      regLow <= '0;
    end else if (stb.loadLow) begin
      regLow <= din[LOW_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      regHigh <= '0;
    end else if (stb.loadHigh) begin
      regHigh <= din[WIDTH-1:LOW_BITS];
    end
  end

  assign regQ    = {regHigh, regLow};
  assign outWord = stb.selBuf ? din : regQ;

  assign portA = stb.drive ? outWord : {WIDTH{1'bz}};
  assign portB = stb.drive ? outWord : {WIDTH{1'bz}};

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (stb.clear)
    stb.loadLow |=> regQ == $past(din)); // R3

  AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (stb.clear)
    1'b1 |=> regHigh == $past(din[WIDTH-1:LOW_BITS])); // R4

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (stb.clear)
    !stb.loadLow |=> $stable(regLow)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    stb.clear |=> regQ == '0); // R9

endmodule

// File: rtl/dual_path_driver.sv
module dual_path_driver
  import dual_path_driver_pkg::*;
#(
  parameter int WIDTH    = 12,
  parameter int LOW_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             clkEnN,
  input  logic             oeN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] portA,
  output logic [WIDTH-1:0] portB
);

  strobe_t stb;

  dual_path_ctrl u_ctrl (
    .rst    (rst),
    .mode   (mode),
    .clkEnN (clkEnN),
    .oeN    (oeN),
    .stb    (stb)
  );

  dual_path_data #(
    .WIDTH    (WIDTH),
    .LOW_BITS (LOW_BITS)
  ) u_data (
    .clk   (clk),
    .stb   (stb),
    .din   (din),
    .portA (portA),
    .portB (portB)
  );

endmodule

// File: tb/sim_dual_path_driver.sv
module sim_dual_path_driver;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode;
  logic        clkEnN;
  logic        oeN;
  logic [11:0] din;
  wire  [11:0] portA;
  wire  [11:0] portB;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_path_driver u0 (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .clkEnN (clkEnN),
    .oeN    (oeN),
    .din    (din),
    .portA  (portA),
    .portB  (portB)
  );

  // vector: {mode, clkEnN, din, expected port value after the edge}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'hA5C, 12'hA5C},  // R3 full load
    {1'b0, 1'b1, 12'h3FF, 12'h35C},  // R4 partial load
    {1'b1, 1'b1, 12'h0F0, 12'h0F0},  // R1 transparent, reg -> 05C
    {1'b0, 1'b1, 12'hFFF, 12'hF5C},  // R4 mixed word via R2
    {1'b0, 1'b0, 12'h123, 12'h123},  // R3
    {1'b1, 1'b0, 12'h987, 12'h987},  // R1, reg -> 987
    {1'b0, 1'b1, 12'h000, 12'h087}   // R4 after transparent load
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkOff(input string req, input logic [11:0] act);
    checks++;
    if (act !== 12'hzzz && act !== 12'h000) begin
      errors++;
      $display("FAIL %s: actual %h expected zzz", req, act);
    end
  endtask

  task automatic edgeStep();
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst = 1'b1; mode = 1'b0; clkEnN = 1'b0; oeN = 1'b0; din = 12'h7E7;
    edgeStep();
    edgeStep();
    check("R9 reset state", portA, 12'h000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      mode   = VEC[i][25];
      clkEnN = VEC[i][24];
      din    = VEC[i][23:12];
      edgeStep();
      check(VEC[i][25] ? "R1 vector" : "R2 R3 R4 vector", portA, VEC[i][11:0]);
      check("R5 copies", portB, portA);
    end

    // R1: combinational response without an edge
    mode = 1'b1; din = 12'h456; #2;
    check("R1 no edge", portA, 12'h456);
    din = 12'hBCD; #2;
    check("R1 no edge second", portB, 12'hBCD);

    // R6 and R7: disabled ports, register still loads
    mode = 1'b0; clkEnN = 1'b0; oeN = 1'b1; din = 12'h5A5;
    edgeStep();
    checkOff("R6 portA off", portA);
    checkOff("R6 portB off", portB);
    oeN = 1'b0; #2;
    check("R7 loaded while off", portA, 12'h5A5);
    oeN = 1'b1; clkEnN = 1'b1; din = 12'hC00;
    edgeStep();
    oeN = 1'b0; #2;
    check("R7 partial load while off", portA, 12'hCA5);

    // R8: mode toggle between edges keeps register
    mode = 1'b1; din = 12'h0FF; #2;
    check("R8 switch to transparent", portA, 12'h0FF);
    mode = 1'b0; #2;
    check("R8 register undisturbed", portB, 12'hCA5);

    // R9: reset mid run wins over full load
    rst = 1'b1; clkEnN = 1'b0; din = 12'hEEE;
    edgeStep();
    check("R9 reset priority", portA, 12'h000);
    rst = 1'b0;
    edgeStep();
    check("R3 after reset", portA, 12'hEEE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule